// File: doc/BRIEF.md
# DMA Channel Status and Error Tracker

This block holds the status byte, the error-code byte and the interrupt request of a single DMA channel. The transfer engine reports its events as one-cycle pulses: operation done, block done, device-signalled termination, a DONE input, an error with its code, an external forced stop and a software abort. The block keeps a record of each event and exposes it through a readable status byte and error byte. It also tracks the channel-active state and decides whether a start request may be accepted.

Most status bits are sticky. Software clears a sticky bit by writing 1 to its position. Two bits are live: channel active and the level of the peripheral control line. A start request is refused while any completion flag, error flag or active flag is still set. A refused start is recorded as an operation timing error.

The interrupt request is raised from the operation-complete flag, subject to an enable control with inverted polarity. The vector presented with it is either the normal vector or the error vector, depending on the error flag.

Top module: `dma_chan_status`

## Requirements
- R1: After reset the status byte reads 0 except bit 0, the error byte reads 0, irq_o is 0 and start_ok_o is 1. Status bit order from 7 down to 0 is: operation complete (COC), block complete, device termination, error, active, DONE-input seen, peripheral-line fall, peripheral-line level.
- R2: The sticky bits (7, 6, 5, 4, 2, 1) stay 1 until a status write with a 1 in that position clears them. Writing 0 has no effect. An event in the same cycle as its clear leaves the bit at 1.
- R3: An accepted start sets the active bit (bit 3). Operation done, device termination, any error or any forced stop clears it. A status write never changes bit 3 or bit 0.
- R4: Bit 0 always equals pline_i. Bit 1 is set one clock after pline_i goes from 1 to 0, and a rising edge does not set it.
- R5: start_ok_o is 1 only while bits 7, 6, 5, 4 and 3 are all 0. A start requested while any of these bits is 1 leaves the active bit at 0, loads error code 00010 and sets bits 4 and 7.
- R6: An error event loads err_code_i into error-byte bits 4..0 and sets bits 4 and 7. Error-byte bits 7..5 read 0. Clearing bit 4 by a write also resets the code to 00000.
- R7: An external stop loads code 10000 and a software abort loads code 10001. Both clear the active bit and set bits 4 and 7. When several error sources coincide, the code priority is software abort, then external stop, then error event, then refused start.
- R8: A DONE input sets bit 2 only while multi_blk_en_i is 1.
- R9: irq_o is 1 exactly when bit 7 is 1 and irq_dis_i is 0. A 1 on irq_dis_i masks the request.
- R10: vec_o equals norm_vec_i while bit 4 is 0 and err_vec_i while bit 4 is 1.
- R11: A device termination sets bits 5 and 7 and clears the active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_done_i | input | 1 | Operation complete pulse |
| blk_done_i | input | 1 | Block complete pulse |
| dev_term_i | input | 1 | Device-signalled termination pulse |
| done_in_i | input | 1 | DONE input pulse |
| multi_blk_en_i | input | 1 | Multiple-block DONE handling enabled |
| err_evt_i | input | 1 | Error event pulse |
| err_code_i | input | 5 | Code carried with err_evt_i |
| ext_stop_i | input | 1 | External forced stop pulse |
| sw_abort_i | input | 1 | Software abort pulse |
| start_req_i | input | 1 | Start request pulse |
| pline_i | input | 1 | Peripheral control line level |
| wr_stat_i | input | 1 | Status byte write strobe |
| wr_data_i | input | 8 | Write data, 1 clears the sticky bit |
| irq_dis_i | input | 1 | 1 disables the interrupt |
| norm_vec_i | input | 8 | Normal interrupt vector |
| err_vec_i | input | 8 | Error interrupt vector |
| status_o | output | 8 | Status byte |
| err_o | output | 8 | Error byte |
| active_o | output | 1 | Channel active |
| start_ok_o | output | 1 | A start would be accepted now |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector to present |

## Verification
Every event reaches status_o and err_o at the clock edge that samples it. This means a lost set, a clear that misses its bit, or a wrong error code can be seen one cycle after the stimulus. A sticky bit that drops on its own appears as a wrong byte at the next status read. A bit that fails to clear appears as start_ok_o stuck at 0 and as irq_o staying asserted, both in the following cycle. A wrong code priority or a wrong vector selection appears only when several error sources fire together, or while the error bit is 1, so those cases are driven on purpose.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned BYTE_W = 8;

  // status bit positions (software-visible order)
  localparam int unsigned B_COC = 7;
  localparam int unsigned B_BTC = 6;
  localparam int unsigned B_NDT = 5;
  localparam int unsigned B_ERR = 4;
  localparam int unsigned B_ACT = 3;
  localparam int unsigned B_DIT = 2;
  localparam int unsigned B_PCT = 1;
  localparam int unsigned B_PCS = 0;

  // sticky flag indices inside the flag bank
  typedef enum logic [2:0] {
    F_COC = 3'd0, F_BTC = 3'd1, F_NDT = 3'd2,
    F_ERR = 3'd3, F_DIT = 3'd4, F_PCT = 3'd5
  } flag_idx_e;
  localparam int unsigned N_FLAGS = 6;

  localparam logic [CODE_W-1:0] C_NONE   = 5'b00000;
  localparam logic [CODE_W-1:0] C_TIMING = 5'b00010;
  localparam logic [CODE_W-1:0] C_EXT    = 5'b10000;
  localparam logic [CODE_W-1:0] C_SOFT   = 5'b10001;
endpackage

// File: rtl/dma_pline_edge.sv
module dma_pline_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pline_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pline_i;
  end

  assign fall_o = prev_q & ~pline_i;

  assert_fall_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> ($past(pline_i) && !pline_i));
endmodule

// File: rtl/dma_sticky_bank.sv
module dma_sticky_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;   // set wins over clear
      else if (clr_i[g]) q <= 1'b0;
    end
    assign q_o[g] = q;

    assert_sticky_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[g]) |=> q);
    assert_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> q);
  end
endmodule

// File: rtl/dma_err_code.sv
module dma_err_code
  import dma_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_abort_i,
  input  logic              ext_stop_i,
  input  logic              err_evt_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic              refuse_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         code_q <= C_NONE;
    else if (sw_abort_i) code_q <= C_SOFT;
    else if (ext_stop_i) code_q <= C_EXT;
    else if (err_evt_i)  code_q <= err_code_i;
    else if (refuse_i)   code_q <= C_TIMING;
    else if (clr_i)      code_q <= C_NONE;
  end

  assign code_o = code_q;

  assert_abort_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_abort_i |=> (code_o == C_SOFT));
  assert_refuse_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refuse_i && !sw_abort_i && !ext_stop_i && !err_evt_i) |=> (code_o == C_TIMING));
  assert_clear_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !sw_abort_i && !ext_stop_i && !err_evt_i && !refuse_i) |=> (code_o == C_NONE));
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_done_i,
  input  logic              blk_done_i,
  input  logic              dev_term_i,
  input  logic              done_in_i,
  input  logic              multi_blk_en_i,
  input  logic              err_evt_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic              ext_stop_i,
  input  logic              sw_abort_i,
  input  logic              start_req_i,
  input  logic              pline_i,
  input  logic              wr_stat_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              irq_dis_i,
  input  logic [BYTE_W-1:0] norm_vec_i,
  input  logic [BYTE_W-1:0] err_vec_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] err_o,
  output logic              active_o,
  output logic              start_ok_o,
  output logic              irq_o,
  output logic [BYTE_W-1:0] vec_o
);
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic [CODE_W-1:0]  code;
  logic               act_q, blocked, accept, refuse, any_err, stop_act, pline_fall;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[B_ACT], wr_data_i[B_PCS]};

  assign blocked  = flag_q[F_COC] | flag_q[F_BTC] | flag_q[F_NDT] | flag_q[F_ERR] | act_q;
  assign accept   = start_req_i & ~blocked;
  assign refuse   = start_req_i & blocked;
  assign any_err  = sw_abort_i | ext_stop_i | err_evt_i | refuse;
  assign stop_act = op_done_i | dev_term_i | any_err;

  dma_pline_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pline_i(pline_i),
    .fall_o (pline_fall)
  );

  always_comb begin
    flag_set        = '0;
    flag_set[F_COC] = op_done_i | dev_term_i | any_err;
    flag_set[F_BTC] = blk_done_i;
    flag_set[F_NDT] = dev_term_i;
    flag_set[F_ERR] = any_err;
    flag_set[F_DIT] = done_in_i & multi_blk_en_i;
    flag_set[F_PCT] = pline_fall;

    flag_clr        = '0;
    flag_clr[F_COC] = wr_stat_i & wr_data_i[B_COC];
    flag_clr[F_BTC] = wr_stat_i & wr_data_i[B_BTC];
    flag_clr[F_NDT] = wr_stat_i & wr_data_i[B_NDT];
    flag_clr[F_ERR] = wr_stat_i & wr_data_i[B_ERR];
    flag_clr[F_DIT] = wr_stat_i & wr_data_i[B_DIT];
    flag_clr[F_PCT] = wr_stat_i & wr_data_i[B_PCT];
  end

  dma_sticky_bank #(.N(N_FLAGS)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_q)
  );

  dma_err_code u_code (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_abort_i(sw_abort_i),
    .ext_stop_i(ext_stop_i),
    .err_evt_i (err_evt_i),
    .err_code_i(err_code_i),
    .refuse_i  (refuse),
    .clr_i     (flag_clr[F_ERR]),
    .code_o    (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_q <= 1'b0;
    else if (accept)   act_q <= 1'b1;
    else if (stop_act) act_q <= 1'b0;
  end

  always_comb begin
    status_o        = '0;
    status_o[B_COC] = flag_q[F_COC];
    status_o[B_BTC] = flag_q[F_BTC];
    status_o[B_NDT] = flag_q[F_NDT];
    status_o[B_ERR] = flag_q[F_ERR];
    status_o[B_ACT] = act_q;
    status_o[B_DIT] = flag_q[F_DIT];
    status_o[B_PCT] = flag_q[F_PCT];
    status_o[B_PCS] = pline_i;
  end

  assign err_o      = {{(BYTE_W-CODE_W){1'b0}}, code};
  assign active_o   = act_q;
  assign start_ok_o = ~blocked;
  assign irq_o      = flag_q[F_COC] & ~irq_dis_i;
  assign vec_o      = flag_q[F_ERR] ? err_vec_i : norm_vec_i;

  assert_refused_stays_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_i && !start_ok_o) |=> (!active_o && status_o[B_ERR] && status_o[B_COC]));
  assert_act_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i || dev_term_i || ext_stop_i || sw_abort_i) |=> !active_o);
  assert_write_keeps_act_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && active_o && !start_req_i && !op_done_i && !dev_term_i && !err_evt_i
     && !ext_stop_i && !sw_abort_i) |=> active_o);
  assert_ndt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_term_i |=> (status_o[B_NDT] && status_o[B_COC]));
  assert_dit_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[B_DIT]) |-> $past(done_in_i && multi_blk_en_i));
  assert_err_top_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[7:5] == 3'b000);
endmodule

// File: tb/dma_chan_status_bench.sv
`timescale 1ns/1ps
module dma_chan_status_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       op_done_i = 0, blk_done_i = 0, dev_term_i = 0, done_in_i = 0, multi_blk_en_i = 0;
  logic       err_evt_i = 0, ext_stop_i = 0, sw_abort_i = 0, start_req_i = 0, pline_i = 1;
  logic [4:0] err_code_i = '0;
  logic       wr_stat_i = 0, irq_dis_i = 0;
  logic [7:0] wr_data_i = '0, norm_vec_i = 8'h40, err_vec_i = 8'h41;
  logic [7:0] status_o, err_o, vec_o;
  logic       active_o, start_ok_o, irq_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  dma_chan_status u_dma_chan_status (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    op_done_i = 0; blk_done_i = 0; dev_term_i = 0; done_in_i = 0; err_evt_i = 0;
    ext_stop_i = 0; sw_abort_i = 0; start_req_i = 0; wr_stat_i = 0; wr_data_i = '0;
  endtask

  task automatic step();
    @(negedge clk_i);
    idle_all();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_stat_i = 1; wr_data_i = d; step();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h01);
    chk("R1 err", err_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 start_ok", {7'd0, start_ok_o}, 8'h01);
  endtask

  task automatic t_start_done();
    start_req_i = 1; step();
    chk("R3 active", status_o, 8'h09);
    chk("R5 start_ok busy", {7'd0, start_ok_o}, 8'h00);
    wr(8'h09);
    chk("R3 write ignored", status_o, 8'h09);
    op_done_i = 1; step();
    chk("R3 done", status_o, 8'h81);
    chk("R9 irq", {7'd0, irq_o}, 8'h01);
    chk("R10 normal vec", vec_o, 8'h40);
    irq_dis_i = 1; #1;
    chk("R9 masked", {7'd0, irq_o}, 8'h00);
    irq_dis_i = 0;
    wr(8'h00);
    chk("R2 write zero", status_o, 8'h81);
    wr(8'h80);
    chk("R2 cleared", status_o, 8'h01);
  endtask

  task automatic t_refuse();
    blk_done_i = 1; step();
    chk("R2 btc", status_o, 8'h41);
    start_req_i = 1; step();
    chk("R5 refused status", status_o, 8'hD1);
    chk("R5 refused code", err_o, 8'h02);
    chk("R10 error vec", vec_o, 8'h41);
    wr(8'hF0);
    chk("R6 cleared status", status_o, 8'h01);
    chk("R6 cleared code", err_o, 8'h00);
  endtask

  task automatic t_errors();
    err_evt_i = 1; err_code_i = 5'b00110; step();
    chk("R6 code", err_o, 8'h06);
    chk("R6 status", status_o, 8'h91);
    wr(8'h90);
    sw_abort_i = 1; ext_stop_i = 1; err_evt_i = 1; err_code_i = 5'b01101; step();
    chk("R7 priority", err_o, 8'h11);
    wr(8'h90);
    ext_stop_i = 1; err_evt_i = 1; step();
    chk("R7 ext over evt", err_o, 8'h10);
    wr(8'h90);
    start_req_i = 1; step();
    sw_abort_i = 1; step();
    chk("R7 abort status", status_o, 8'h91);
    chk("R7 abort code", err_o, 8'h11);
    wr(8'h90);
  endtask

  task automatic t_pline();
    pline_i = 0; step();
    chk("R4 fall", status_o, 8'h02);
    pline_i = 1; step();
    chk("R4 level", status_o, 8'h03);
    wr(8'h02);
    chk("R4 rise no set", status_o, 8'h01);
  endtask

  task automatic t_dit_ndt();
    done_in_i = 1; multi_blk_en_i = 0; step();
    chk("R8 gated", status_o, 8'h01);
    done_in_i = 1; multi_blk_en_i = 1; step();
    chk("R8 set", status_o, 8'h05);
    wr(8'h04);
    start_req_i = 1; step();
    dev_term_i = 1; step();
    chk("R11 ndt", status_o, 8'hA1);
    chk("R11 inactive", {7'd0, active_o}, 8'h00);
    op_done_i = 1; wr_stat_i = 1; wr_data_i = 8'hA0; step();
    chk("R2 set wins", status_o, 8'h81);
    wr(8'h80);
    chk("R2 final", status_o, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_start_done();
    t_refuse();
    t_errors();
    t_pline();
    t_dit_ndt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule